// File: doc/BRIEF.md
# Banked Data Memory Controller

This block sits between an 8-bit processor core and its data storage. Every data address from the core is 8 bits wide. The block turns each address into a physical location, using an 8-bit bank selector held inside the block. The selector is split into two nibbles that work independently. The lower nibble picks which peripheral register bank appears in an eight-register window. The upper nibble picks which general-purpose RAM bank appears in the upper part of the address space. The remaining low addresses are common to all banks and do not depend on the selector.

The core changes the selector with two load commands. One command writes the lower nibble and the other writes the upper nibble, so one bank space can be changed without disturbing the other. If an access targets a bank that does not exist, the block absorbs it. A read returns zero and a write changes nothing. One peripheral bank number is reserved. Reads from it return a filler pattern and the access is flagged. An access result appears one clock after the access is presented, and a hit flag tells real accesses apart from absorbed ones.

Top module: `banked_mem_ctrl`

## Requirements
- R1: After reset the bank selector `bank_sel` reads 00h.
- R2: A low-nibble load (`ld_lo`) writes `ld_value` into `bank_sel[3:0]` and leaves `bank_sel[7:4]` unchanged. The new value is visible on `bank_sel` one clock later.
- R3: A high-nibble load (`ld_hi`) writes `ld_value` into `bank_sel[7:4]` and leaves `bank_sel[3:0]` unchanged.
- R4: Addresses 10h to 17h select one of eight registers in the peripheral bank named by `bank_sel[3:0]`. Banks 0 to PERIPH_BANKS-1 (default 0 to 8) each hold separate storage. A write followed by a read returns the written byte with `acc_hit`=1.
- R5: Peripheral bank numbers from PERIPH_BANKS to 14 are unimplemented. A read from one of them returns 00h with `acc_hit`=0 and `acc_resv`=0. A write to one of them changes no storage.
- R6: Peripheral bank 15 is reserved. A read returns the filler pattern, which is RESV_FILL = A5h by default. Any access to this bank gives `acc_resv`=1 and `acc_hit`=0. A write to it changes no storage.
- R7: Addresses 20h to FFh select a location in the RAM bank named by `bank_sel[7:4]`. Banks 0 to RAM_BANKS-1 (default 0 to 3) each hold separate storage.
- R8: RAM bank numbers at or above RAM_BANKS are unimplemented. A read returns 00h with `acc_hit`=0. A write changes no storage, including the implemented bank whose number shares the low bits.
- R9: Addresses 00h to 0Fh and 18h to 1Fh reach the same locations whatever the value of `bank_sel`, and always give `acc_hit`=1.
- R10: An access presented in clock N is reported after edge N. For a read, `rd_valid` is 1 for exactly that one cycle. `acc_hit` is 1 for that cycle only if the access reached an implemented location. When `rd_valid` is 0, `rd_data` is 00h.
- R11: An access presented in the same clock as a bank load uses the selector value from before the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_write | input | 1 | 1 for a write, 0 for a read |
| acc_addr | input | 8 | Data address from the core |
| acc_wdata | input | 8 | Write byte |
| ld_lo | input | 1 | Load `ld_value` into the lower selector nibble |
| ld_hi | input | 1 | Load `ld_value` into the upper selector nibble |
| ld_value | input | 4 | Nibble value for the bank load commands |
| bank_sel | output | 8 | Current bank selector |
| rd_data | output | 8 | Read result, valid with `rd_valid` |
| rd_valid | output | 1 | Read result present this cycle |
| acc_hit | output | 1 | The reported access reached an implemented location |
| acc_resv | output | 1 | The reported access targeted the reserved peripheral bank |

## Verification
Each access result (`rd_data`, `rd_valid`, `acc_hit`, `acc_resv`) is due one cycle after the access is presented. A selector load shows on `bank_sel` one cycle after its command. The bench drives inputs on the falling edge. It holds each access for one rising edge and samples outputs on the next falling edge, which is the cycle the result is due. It then checks that the flags are low again on the idle cycle that follows. The same-cycle case presents a load and a read together. It expects data from the old bank in the result and the new selector value on `bank_sel`.

// File: rtl/bmc_pkg.sv
package bmc_pkg;

  typedef enum logic [1:0] {
    RGN_COMMON = 2'd0,
    RGN_PERIPH = 2'd1,
    RGN_GPR    = 2'd2
  } region_e;

  localparam logic [7:0] WIN_LO   = 8'h10;
  localparam logic [7:0] WIN_HI   = 8'h17;
  localparam logic [7:0] GPR_BASE = 8'h20;
  localparam logic [3:0] RESV_BANK = 4'hF;

  function automatic logic is_common(input logic [7:0] a);
    return (a < WIN_LO) || (a > WIN_HI && a < GPR_BASE);
  endfunction

endpackage

// File: rtl/bmc_bank_reg.sv
module bmc_bank_reg (
  input  logic       clk,
  input  logic       rst,
  input  logic       ld_lo,
  input  logic       ld_hi,
  input  logic [3:0] ld_value,
  output logic [7:0] sel
);
  logic [3:0] lo_q, hi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q <= 4'h0;
      hi_q <= 4'h0;
    end else begin
      if (ld_lo) lo_q <= ld_value;
      if (ld_hi) hi_q <= ld_value;
    end
  end

  assign sel = {hi_q, lo_q};
endmodule

// File: rtl/bmc_decode.sv
module bmc_decode
  import bmc_pkg::*;
#(
  parameter int PERIPH_BANKS = 9,
  parameter int RAM_BANKS    = 4,
  parameter int P_AW         = 7,
  parameter int G_AW         = 10
) (
  input  logic [7:0]      addr,
  input  logic [7:0]      sel,
  output region_e         region,
  output logic            impl,
  output logic            resv,
  output logic [4:0]      c_idx,
  output logic [P_AW-1:0] p_idx,
  output logic [G_AW-1:0] g_idx
);
  logic [3:0] pbank, gbank;
  logic [6:0] p_full;
  logic [11:0] g_full;

  assign pbank  = sel[3:0];
  assign gbank  = sel[7:4];
  assign p_full = {pbank, addr[2:0]};
  assign g_full = {gbank, addr};
  assign c_idx  = addr[4:0];
  assign p_idx  = P_AW'(p_full);
  assign g_idx  = G_AW'(g_full);

  always_comb begin
    region = RGN_COMMON;
    impl   = 1'b1;
    resv   = 1'b0;
    if (!is_common(addr)) begin
      if (addr < GPR_BASE) begin
        region = RGN_PERIPH;
        resv   = (pbank == RESV_BANK);
        impl   = (32'(pbank) < PERIPH_BANKS) && !resv;
      end else begin
        region = RGN_GPR;
        impl   = (32'(gbank) < RAM_BANKS);
      end
    end
  end
endmodule

// File: rtl/bmc_ram.sv
module bmc_ram #(
  parameter int DEPTH  = 32,
  parameter int DATA_W = 8,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      rdata <= mem[addr];
    end
  end
endmodule

// File: rtl/banked_mem_ctrl.sv
module banked_mem_ctrl
  import bmc_pkg::*;
#(
  parameter int         PERIPH_BANKS = 9,
  parameter int         RAM_BANKS    = 4,
  parameter bit         RESV_LFSR    = 1'b0,
  parameter logic [7:0] RESV_FILL    = 8'hA5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       acc_valid,
  input  logic       acc_write,
  input  logic [7:0] acc_addr,
  input  logic [7:0] acc_wdata,
  input  logic       ld_lo,
  input  logic       ld_hi,
  input  logic [3:0] ld_value,
  output logic [7:0] bank_sel,
  output logic [7:0] rd_data,
  output logic       rd_valid,
  output logic       acc_hit,
  output logic       acc_resv
);
  localparam int C_DEPTH = 32;
  localparam int P_DEPTH = PERIPH_BANKS * 8;
  localparam int G_DEPTH = RAM_BANKS * 256;
  localparam int P_AW    = $clog2(P_DEPTH);
  localparam int G_AW    = $clog2(G_DEPTH);

  region_e         d_region;
  logic            d_impl, d_resv;
  logic [4:0]      d_cidx;
  logic [P_AW-1:0] d_pidx;
  logic [G_AW-1:0] d_gidx;

  bmc_bank_reg u_sel (
    .clk(clk), .rst(rst), .ld_lo(ld_lo), .ld_hi(ld_hi),
    .ld_value(ld_value), .sel(bank_sel)
  );

  bmc_decode #(
    .PERIPH_BANKS(PERIPH_BANKS), .RAM_BANKS(RAM_BANKS),
    .P_AW(P_AW), .G_AW(G_AW)
  ) u_dec (
    .addr(acc_addr), .sel(bank_sel), .region(d_region), .impl(d_impl),
    .resv(d_resv), .c_idx(d_cidx), .p_idx(d_pidx), .g_idx(d_gidx)
  );

  logic c_en, p_en, g_en;
  logic [7:0] c_q, p_q, g_q;

  assign c_en = acc_valid && d_impl && (d_region == RGN_COMMON);
  assign p_en = acc_valid && d_impl && (d_region == RGN_PERIPH);
  assign g_en = acc_valid && d_impl && (d_region == RGN_GPR);

  bmc_ram #(.DEPTH(C_DEPTH), .DATA_W(8)) u_cram (
    .clk(clk), .en(c_en), .we(acc_write), .addr(d_cidx),
    .wdata(acc_wdata), .rdata(c_q)
  );
  bmc_ram #(.DEPTH(P_DEPTH), .DATA_W(8)) u_pram (
    .clk(clk), .en(p_en), .we(acc_write), .addr(d_pidx),
    .wdata(acc_wdata), .rdata(p_q)
  );
  bmc_ram #(.DEPTH(G_DEPTH), .DATA_W(8)) u_gram (
    .clk(clk), .en(g_en), .we(acc_write), .addr(d_gidx),
    .wdata(acc_wdata), .rdata(g_q)
  );

  // Filler pattern for the reserved bank
  logic [7:0] fill;
  generate
    if (RESV_LFSR) begin : g_fill_lfsr
      logic [7:0] lfsr_q;
      always_ff @(posedge clk) begin
        if (rst) lfsr_q <= RESV_FILL | 8'h01;
        else if (acc_valid && d_resv && !acc_write)
          lfsr_q <= {lfsr_q[6:0], 1'b0} ^ (lfsr_q[7] ? 8'h1D : 8'h00);
      end
      assign fill = lfsr_q;
    end else begin : g_fill_fixed
      assign fill = RESV_FILL;
    end
  endgenerate

  // Result stage
  region_e    r_region;
  logic       r_read, r_hit, r_resv;
  logic [7:0] r_fill;

  always_ff @(posedge clk) begin
    if (rst) begin
      r_region <= RGN_COMMON;
      r_read   <= 1'b0;
      r_hit    <= 1'b0;
      r_resv   <= 1'b0;
      r_fill   <= 8'h00;
    end else begin
      r_region <= d_region;
      r_read   <= acc_valid && !acc_write;
      r_hit    <= acc_valid && d_impl;
      r_resv   <= acc_valid && d_resv;
      r_fill   <= fill;
    end
  end

  always_comb begin
    rd_data = 8'h00;
    if (r_read) begin
      if (r_resv) rd_data = r_fill;
      else if (r_hit) begin
        unique case (r_region)
          RGN_COMMON: rd_data = c_q;
          RGN_PERIPH: rd_data = p_q;
          RGN_GPR:    rd_data = g_q;
          default:    rd_data = 8'h00;
        endcase
      end
    end
  end

  assign rd_valid = r_read;
  assign acc_hit  = r_hit;
  assign acc_resv = r_resv;
endmodule

// File: rtl/banked_mem_ctrl_chk.sv
module banked_mem_ctrl_chk #(
  parameter bit         RESV_LFSR = 1'b0,
  parameter logic [7:0] RESV_FILL = 8'hA5
) (
  input logic       clk,
  input logic       rst,
  input logic       acc_valid,
  input logic       acc_write,
  input logic [7:0] acc_addr,
  input logic       ld_lo,
  input logic       ld_hi,
  input logic [3:0] ld_value,
  input logic [7:0] bank_sel,
  input logic [7:0] rd_data,
  input logic       rd_valid,
  input logic       acc_hit,
  input logic       acc_resv
);
  logic unb;
  assign unb = (acc_addr < 8'h10) || (acc_addr >= 8'h18 && acc_addr < 8'h20);

  // R1
  sel_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> bank_sel == 8'h00);

  // R2
  lo_load_chk: assert property (@(posedge clk) disable iff (rst)
    (ld_lo && !ld_hi) |=> (bank_sel[3:0] == $past(ld_value)) &&
                          (bank_sel[7:4] == $past(bank_sel[7:4])));

  // R3
  hi_load_chk: assert property (@(posedge clk) disable iff (rst)
    (ld_hi && !ld_lo) |=> (bank_sel[7:4] == $past(ld_value)) &&
                          (bank_sel[3:0] == $past(bank_sel[3:0])));

  // R6
  resv_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_resv && rd_valid && !RESV_LFSR) |-> rd_data == RESV_FILL);

  // R6
  resv_nohit_chk: assert property (@(posedge clk) disable iff (rst)
    acc_resv |-> !acc_hit);

  // R5
  absorbed_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !acc_hit && !acc_resv) |-> rd_data == 8'h00);

  // R9
  common_hit_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && unb) |=> acc_hit);

  // R10
  rd_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !acc_write) |=> rd_valid);

  // R10
  rd_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !(acc_valid && !acc_write) |=> (!rd_valid && rd_data == 8'h00));

  // R10
  hit_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> (!acc_hit && !acc_resv));
endmodule

bind banked_mem_ctrl banked_mem_ctrl_chk #(
  .RESV_LFSR(RESV_LFSR), .RESV_FILL(RESV_FILL)
) u_chk (
  .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
  .acc_addr(acc_addr), .ld_lo(ld_lo), .ld_hi(ld_hi), .ld_value(ld_value),
  .bank_sel(bank_sel), .rd_data(rd_data), .rd_valid(rd_valid),
  .acc_hit(acc_hit), .acc_resv(acc_resv)
);

// File: tb/sim_banked_mem_ctrl.sv
`timescale 1ns/1ps
module sim_banked_mem_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       acc_valid = 1'b0, acc_write = 1'b0;
  logic [7:0] acc_addr = 8'h00, acc_wdata = 8'h00;
  logic       ld_lo = 1'b0, ld_hi = 1'b0;
  logic [3:0] ld_value = 4'h0;
  logic [7:0] bank_sel, rd_data;
  logic       rd_valid, acc_hit, acc_resv;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  banked_mem_ctrl u0 (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .ld_lo(ld_lo), .ld_hi(ld_hi),
    .ld_value(ld_value), .bank_sel(bank_sel), .rd_data(rd_data),
    .rd_valid(rd_valid), .acc_hit(acc_hit), .acc_resv(acc_resv)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Presents one access for one edge; returns the results due after it.
  task automatic access(input bit wr, input logic [7:0] a, input logic [7:0] d,
                        output logic [7:0] q, output logic hit, output logic rv,
                        output logic rs);
    acc_valid = 1'b1; acc_write = wr; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0;
    q = rd_data; hit = acc_hit; rv = rd_valid; rs = acc_resv;
  endtask

  task automatic load(input bit hi, input logic [3:0] v);
    ld_lo = !hi; ld_hi = hi; ld_value = v;
    @(negedge clk);
    ld_lo = 1'b0; ld_hi = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    logic [7:0] q; logic h, v, s;
    access(1'b1, a, d, q, h, v, s);
  endtask

  task automatic t_reset;
    chk("R1 bank_sel", bank_sel, 8'h00);
    chk("R10 rd_valid idle", {7'd0, rd_valid}, 8'h00);
    chk("R10 hit idle", {7'd0, acc_hit}, 8'h00);
  endtask

  task automatic t_loads;
    load(1'b0, 4'h5);
    chk("R2 low load", bank_sel, 8'h05);
    load(1'b1, 4'h3);
    chk("R3 high load", bank_sel, 8'h35);
    load(1'b0, 4'h9);
    chk("R2 high kept", bank_sel, 8'h39);
    load(1'b1, 4'hC);
    chk("R3 low kept", bank_sel, 8'hC9);
    load(1'b0, 4'h0); load(1'b1, 4'h0);
  endtask

  task automatic t_periph;
    logic [7:0] q; logic h, v, s;
    load(1'b0, 4'h0); wr(8'h10, 8'h0A); wr(8'h17, 8'h0B);
    load(1'b0, 4'h8); wr(8'h10, 8'h8A); wr(8'h17, 8'h8B);
    access(1'b0, 8'h10, 8'h00, q, h, v, s);
    chk("R4 bank8 10h", q, 8'h8A); chk("R4 bank8 hit", {7'd0, h}, 8'h01);
    access(1'b0, 8'h17, 8'h00, q, h, v, s);
    chk("R4 bank8 17h", q, 8'h8B);
    load(1'b0, 4'h0);
    access(1'b0, 8'h10, 8'h00, q, h, v, s);
    chk("R4 bank0 10h", q, 8'h0A);
    access(1'b0, 8'h17, 8'h00, q, h, v, s);
    chk("R4 bank0 17h", q, 8'h0B);
  endtask

  task automatic t_periph_unimpl;
    logic [7:0] q; logic h, v, s;
    load(1'b0, 4'h1); wr(8'h15, 8'h11);
    for (int b = 9; b <= 14; b++) begin
      load(1'b0, 4'(b));
      wr(8'h15, 8'h5A);
      access(1'b0, 8'h15, 8'h00, q, h, v, s);
      chk("R5 unimpl read zero", q, 8'h00);
      chk("R5 unimpl flags", {5'd0, h, v, s}, 8'h02);
    end
    load(1'b0, 4'h1);
    access(1'b0, 8'h15, 8'h00, q, h, v, s);
    chk("R5 impl bank untouched", q, 8'h11);
  endtask

  task automatic t_reserved;
    logic [7:0] q; logic h, v, s;
    load(1'b0, 4'h7); wr(8'h13, 8'h77);
    load(1'b0, 4'hF);
    access(1'b0, 8'h13, 8'h00, q, h, v, s);
    chk("R6 fill", q, 8'hA5); chk("R6 flags", {5'd0, h, v, s}, 8'h03);
    access(1'b1, 8'h13, 8'h99, q, h, v, s);
    chk("R6 write flags", {5'd0, h, v, s}, 8'h01);
    access(1'b0, 8'h13, 8'h00, q, h, v, s);
    chk("R6 fill after write", q, 8'hA5);
    load(1'b0, 4'h7);
    access(1'b0, 8'h13, 8'h00, q, h, v, s);
    chk("R6 bank7 untouched", q, 8'h77);
  endtask

  task automatic t_gpr;
    logic [7:0] q; logic h, v, s;
    for (int b = 0; b < 4; b++) begin
      load(1'b1, 4'(b));
      wr(8'h20, 8'(8'h20 + b)); wr(8'hFF, 8'(8'hF0 + b)); wr(8'h80, 8'(8'h40 + b));
    end
    for (int b = 3; b >= 0; b--) begin
      load(1'b1, 4'(b));
      access(1'b0, 8'h20, 8'h00, q, h, v, s);
      chk("R7 gpr 20h", q, 8'(8'h20 + b));
      access(1'b0, 8'hFF, 8'h00, q, h, v, s);
      chk("R7 gpr FFh", q, 8'(8'hF0 + b));
      chk("R7 gpr hit", {7'd0, h}, 8'h01);
    end
  endtask

  task automatic t_gpr_unimpl;
    logic [7:0] q; logic h, v, s;
    load(1'b1, 4'h5);
    access(1'b1, 8'h80, 8'hEE, q, h, v, s);
    chk("R8 write no hit", {7'd0, h}, 8'h00);
    access(1'b0, 8'h80, 8'h00, q, h, v, s);
    chk("R8 read zero", q, 8'h00);
    chk("R8 read flags", {5'd0, h, v, s}, 8'h02);
    load(1'b1, 4'h1);
    access(1'b0, 8'h80, 8'h00, q, h, v, s);
    chk("R8 alias bank untouched", q, 8'h41);
  endtask

  task automatic t_common;
    logic [7:0] q; logic h, v, s;
    load(1'b0, 4'h0); load(1'b1, 4'h0);
    wr(8'h05, 8'h6C); wr(8'h1C, 8'h3D);
    load(1'b0, 4'hF); load(1'b1, 4'hF);
    access(1'b0, 8'h05, 8'h00, q, h, v, s);
    chk("R9 05h sel FF", q, 8'h6C); chk("R9 hit", {7'd0, h}, 8'h01);
    access(1'b0, 8'h1C, 8'h00, q, h, v, s);
    chk("R9 1Ch sel FF", q, 8'h3D);
    load(1'b0, 4'h9); load(1'b1, 4'h7);
    access(1'b0, 8'h1C, 8'h00, q, h, v, s);
    chk("R9 1Ch sel 79", q, 8'h3D);
  endtask

  task automatic t_timing;
    logic [7:0] q; logic h, v, s;
    load(1'b0, 4'h0); load(1'b1, 4'h0);
    access(1'b0, 8'h05, 8'h00, q, h, v, s);
    chk("R10 read valid", {6'd0, v, h}, 8'h03);
    @(negedge clk);
    chk("R10 one-cycle valid", {6'd0, rd_valid, acc_hit}, 8'h00);
    chk("R10 idle data", rd_data, 8'h00);
    access(1'b1, 8'h06, 8'h12, q, h, v, s);
    chk("R10 write flags", {6'd0, v, h}, 8'h01);
    chk("R10 write data", q, 8'h00);
  endtask

  task automatic t_same_cycle;
    logic [7:0] q; logic h, v, s;
    load(1'b0, 4'h3); wr(8'h12, 8'h33);
    load(1'b0, 4'h2); wr(8'h12, 8'h22);
    ld_lo = 1'b1; ld_value = 4'h3;
    access(1'b0, 8'h12, 8'h00, q, h, v, s);
    ld_lo = 1'b0;
    chk("R11 old bank data", q, 8'h22);
    chk("R11 new sel", bank_sel, 8'h03);
    access(1'b0, 8'h12, 8'h00, q, h, v, s);
    chk("R11 next access new bank", q, 8'h33);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_loads();
    t_periph();
    t_periph_unimpl();
    t_reserved();
    t_gpr();
    t_gpr_unimpl();
    t_common();
    t_timing();
    t_same_cycle();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule